// File: doc/BRIEF.md
# Programmable Pulse Pattern Sequencer

This block drives a 12-bit word of digital output lines from a small stored program. Each program word carries an output pattern, a 3-bit opcode, a 20-bit operand and a dwell time in clock cycles. The sequencer fetches one word at a time from a 4096-entry synchronous memory. It drives the word's pattern and holds it for exactly the dwell time. It then goes on to the address that the opcode selects. Dwell values below five cycles are raised to five.

Control flow uses two hardware stacks of eight entries each. One stack holds loop return addresses with 20-bit pass counters. The other holds subroutine return addresses. A wait instruction parks the sequencer on its pattern until a fresh rising edge arrives on the trigger input. The next pattern then follows after a fixed latency.

The program is loaded through a write port, which only takes effect while the sequencer is not running. A start pulse runs the program from address 0. A stack misuse latches an error flag, freezes the lines and halts the sequencer until reset.

Top module: `pulse_seq`

## Requirements
- R1: While rst_n is low at a rising clock edge, dout becomes 0, err becomes 0, the program counter returns to address 0, both stacks are emptied, and the sequencer is idle.
- R2: A start pulse sampled high at rising edge S while idle runs the program from address 0. The first pattern appears on dout at edge S+2, and dout holds its previous value at edge S+1.
- R3: A pattern that appears at edge E is replaced at edge E+D, where D is the dwell of its word. Every bit of dout may change at that boundary.
- R4: A dwell field below 5 (including 0) behaves as a dwell of 5.
- R5: Opcode 2 (loop) pushes the address after itself with its operand N as a counter, then continues at the next address. Opcode 3 (end loop), with a nonzero counter on top, decrements it and jumps to the stored address. With a zero counter it pops and continues at the next address. The body therefore runs N+1 times, and eight loops may be nested.
- R6: Opcode 4 (call) pushes the next address and jumps to operand bits [11:0]. Opcode 5 (return) pops and jumps to the popped address. Opcode 6 (branch) jumps to operand bits [11:0]. Opcode 0 continues at the next address. Calls may be nested eight deep.
- R7: Opcode 7 (wait) drives its pattern and ignores its dwell. It waits for a trigger edge, defined as trig sampled high at edge T after being sampled low at edge T-1. A trigger held high from before the wait does not count. The next pattern appears at edge T+8.
- R8: A loop or call executed when its stack already holds eight entries, or an end loop or return executed on an empty stack, sets err at the edge where that word's pattern would have appeared. dout keeps its previous value. err and dout then stay frozen, and start is ignored, until reset.
- R9: Opcode 1 (stop) drives its pattern and holds it while the sequencer is idle. A later start pulse runs the program again from address 0.
- R10: Writes to program memory take effect only while the sequencer is idle or halted. A write attempted during a run leaves the stored program unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin execution at address 0 when idle |
| trig | input | 1 | External trigger, edge-detected in the wait state |
| wr_en | input | 1 | Program memory write strobe |
| wr_addr | input | 12 | Program memory write address |
| wr_pattern | input | 12 | Pattern field of the word written |
| wr_op | input | 3 | Opcode field of the word written |
| wr_operand | input | 20 | Operand field (count or target address) |
| wr_dur | input | 32 | Dwell field in clock cycles |
| dout | output | 12 | Registered output pattern |
| err | output | 1 | Sticky stack fault flag |

## Verification
Two functions can land on the same clock edge. The first pair is the stack-fault detection and the pattern update it must suppress: the ninth nested loop or call, and a return or end loop on an empty stack, all reach the edge where a new pattern would be driven. The bench judges that edge by err rising while dout keeps the older value. The second pair is the write port and a running program. A memory write is driven into the middle of a long dwell, just before the target word is fetched, and the next pattern must still come from the original word. A directed wait test places the trigger edge against a trigger already held high, and checks the edge eight cycles later against the bench's own cycle count.

// File: rtl/pseq_pkg.sv
// Shared opcode and state encodings for the pulse pattern sequencer.
// Assumes a 3-bit opcode field in every program word.
package pseq_pkg;
    typedef enum logic [2:0] {
        OP_NEXT = 3'd0,
        OP_HALT = 3'd1,
        OP_LOOP = 3'd2,
        OP_ENDL = 3'd3,
        OP_CALL = 3'd4,
        OP_RET  = 3'd5,
        OP_JUMP = 3'd6,
        OP_WAIT = 3'd7
    } seq_op_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_LOAD,
        S_EXEC,
        S_WAIT,
        S_HALT
    } seq_state_t;
endpackage

// File: rtl/pseq_mem.sv
// Program store: one write port and one registered read port.
// Assumes the caller gates the write strobe; the read data follows raddr by one cycle.
module pseq_mem #(
    parameter int AW = 12,
    parameter int DW = 67
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] store [WORDS];

    // write the addressed word and register the read word
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
        rdata <= store[raddr];
    end
endmodule

// File: rtl/pseq_stack.sv
// LIFO of DEPTH entries with push, pop and overwrite-top.
// Assumes the caller checks full/empty; illegal operations are ignored here.
module pseq_stack #(
    parameter int W     = 12,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic         pop,
    input  logic         wr_top,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         empty,
    output logic         full
);
    localparam int SP_W = $clog2(DEPTH + 1);
    localparam int IX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]    ent [DEPTH];
    logic [SP_W-1:0] sp;
    logic [IX_W-1:0] top_ix;
    logic [IX_W-1:0] new_ix;

    assign empty  = (sp == '0);
    assign full   = (sp == SP_W'(DEPTH));
    assign top_ix = IX_W'(sp - SP_W'(1));
    assign new_ix = IX_W'(sp);
    assign top    = empty ? '0 : ent[top_ix];

    // track the fill level
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sp <= '0;
        end else if (push && !full) begin
            sp <= sp + SP_W'(1);
        end else if (pop && !empty) begin
            sp <= sp - SP_W'(1);
        end
    end

    // store a pushed entry or rewrite the top entry
    always_ff @(posedge clk) begin
        if (push && !full) begin
            ent[new_ix] <= din;
        end else if (wr_top && !empty) begin
            ent[top_ix] <= din;
        end
    end
endmodule

// File: rtl/pulse_seq.sv
// Pulse pattern sequencer top: fetches program words, drives their patterns for
// the programmed dwell, and follows loop, call, branch, wait and stop opcodes.
// Assumes MIN_DUR >= 3 and TRIG_LAT >= 3 (fetch and load take two cycles) and CNT_W >= ADDR_W.
module pulse_seq
    import pseq_pkg::*;
#(
    parameter int OUT_W    = 12,
    parameter int ADDR_W   = 12,
    parameter int CNT_W    = 20,
    parameter int DUR_W    = 32,
    parameter int DEPTH    = 8,
    parameter int MIN_DUR  = 5,
    parameter int TRIG_LAT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              trig,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [OUT_W-1:0]  wr_pattern,
    input  logic [2:0]        wr_op,
    input  logic [CNT_W-1:0]  wr_operand,
    input  logic [DUR_W-1:0]  wr_dur,
    output logic [OUT_W-1:0]  dout,
    output logic              err
);
    localparam int OP_W    = 3;
    localparam int WORD_W  = OUT_W + OP_W + CNT_W + DUR_W;
    localparam int OPD_LSB = DUR_W;
    localparam int OP_LSB  = DUR_W + CNT_W;
    localparam int PAT_LSB = OP_LSB + OP_W;
    localparam int LOOP_W  = ADDR_W + CNT_W;
    localparam int PIPE    = 3;
    localparam logic [DUR_W-1:0] MIN_D   = DUR_W'(MIN_DUR);
    localparam logic [DUR_W-1:0] LAT_CNT = DUR_W'(TRIG_LAT - PIPE);

    seq_state_t        state_q;
    logic [ADDR_W-1:0] pc_q, pc_inc, pc_nxt, target;
    logic [DUR_W-1:0]  cnt_q, ins_dur, dur_eff;
    logic [OUT_W-1:0]  dout_q, ins_pat;
    logic [CNT_W-1:0]  ins_opd, lp_cnt;
    logic [ADDR_W-1:0] lp_addr, cs_top;
    logic [WORD_W-1:0] rdata;
    logic [LOOP_W-1:0] lp_din, lp_top;
    seq_op_t           ins_op;
    logic              err_q, trig_q, in_load, go, fault, lp_more;
    logic              lp_push, lp_pop, lp_wr, lp_empty, lp_full;
    logic              cs_push, cs_pop, cs_empty, cs_full, mem_we;

    assign dout = dout_q;
    assign err  = err_q;

    // word fields and derived control values
    assign ins_pat = rdata[PAT_LSB +: OUT_W];
    assign ins_op  = seq_op_t'(rdata[OP_LSB +: OP_W]);
    assign ins_opd = rdata[OPD_LSB +: CNT_W];
    assign ins_dur = rdata[DUR_W-1:0];
    assign dur_eff = (ins_dur < MIN_D) ? MIN_D : ins_dur;
    assign target  = ins_opd[ADDR_W-1:0];
    assign pc_inc  = pc_q + ADDR_W'(1);
    assign in_load = (state_q == S_LOAD);
    assign go      = (state_q == S_IDLE) && start;
    assign mem_we  = wr_en && ((state_q == S_IDLE) || (state_q == S_HALT));
    assign {lp_addr, lp_cnt} = lp_top;
    assign lp_more = (lp_cnt != '0);

    pseq_mem #(.AW(ADDR_W), .DW(WORD_W)) i_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (wr_addr),
        .wdata ({wr_pattern, wr_op, wr_operand, wr_dur}),
        .raddr (pc_q),
        .rdata (rdata)
    );

    // stack strobes for the word being loaded
    assign lp_push = in_load && (ins_op == OP_LOOP);
    assign lp_wr   = in_load && (ins_op == OP_ENDL) && lp_more;
    assign lp_pop  = in_load && (ins_op == OP_ENDL) && !lp_more;
    assign cs_push = in_load && (ins_op == OP_CALL);
    assign cs_pop  = in_load && (ins_op == OP_RET);
    assign lp_din  = lp_push ? {pc_inc, ins_opd} : {lp_addr, lp_cnt - CNT_W'(1)};

    pseq_stack #(.W(LOOP_W), .DEPTH(DEPTH)) i_loop_stk (
        .clk(clk), .rst_n(rst_n), .clr(go), .push(lp_push), .pop(lp_pop),
        .wr_top(lp_wr), .din(lp_din), .top(lp_top), .empty(lp_empty), .full(lp_full)
    );

    pseq_stack #(.W(ADDR_W), .DEPTH(DEPTH)) i_call_stk (
        .clk(clk), .rst_n(rst_n), .clr(go), .push(cs_push), .pop(cs_pop),
        .wr_top(1'b0), .din(pc_inc), .top(cs_top), .empty(cs_empty), .full(cs_full)
    );

    // stack misuse detection for the loaded opcode
    always_comb begin
        case (ins_op)
            OP_LOOP: fault = lp_full;
            OP_ENDL: fault = lp_empty;
            OP_CALL: fault = cs_full;
            OP_RET:  fault = cs_empty;
            default: fault = 1'b0;
        endcase
    end

    // next program address for the loaded opcode
    always_comb begin
        case (ins_op)
            OP_ENDL: pc_nxt = lp_more ? lp_addr : pc_inc;
            OP_CALL: pc_nxt = target;
            OP_RET:  pc_nxt = cs_top;
            OP_JUMP: pc_nxt = target;
            default: pc_nxt = pc_inc;
        endcase
    end

    // trigger history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig;
    end

    // sequencing state machine, dwell counter and output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            pc_q    <= '0;
            cnt_q   <= '0;
            dout_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: if (start) begin
                    pc_q    <= '0;
                    state_q <= S_FETCH;
                end
                S_FETCH: state_q <= S_LOAD;
                S_LOAD: if (fault) begin
                    err_q   <= 1'b1;
                    state_q <= S_HALT;
                end else begin
                    dout_q <= ins_pat;
                    pc_q   <= pc_nxt;
                    cnt_q  <= dur_eff - DUR_W'(PIPE);
                    case (ins_op)
                        OP_HALT: state_q <= S_IDLE;
                        OP_WAIT: state_q <= S_WAIT;
                        default: state_q <= S_EXEC;
                    endcase
                end
                S_EXEC: if (cnt_q == '0) state_q <= S_FETCH;
                        else             cnt_q   <= cnt_q - DUR_W'(1);
                S_WAIT: if (trig && !trig_q) begin
                    cnt_q   <= LAT_CNT;
                    state_q <= S_EXEC;
                end
                default: state_q <= S_HALT;
            endcase
        end
    end
endmodule

// File: rtl/pulse_seq_chk.sv
// Property checker for pulse_seq, attached by bind below.
// Assumes it sees the top's ports and its state register.
module pulse_seq_chk
    import pseq_pkg::*;
#(
    parameter int OUT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             trig,
    input logic [OUT_W-1:0] dout,
    input logic             err,
    input seq_state_t       st
);
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dout == '0 && !err));                          // R1
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);                                                    // R8
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> $stable(dout));                                          // R8
    AST_WAIT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAIT && !trig) |=> (st == S_WAIT));                     // R7
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && !start) |=> (st == S_IDLE && $stable(dout)));   // R9
endmodule

bind pulse_seq pulse_seq_chk #(.OUT_W(OUT_W)) i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .trig  (trig),
    .dout  (dout),
    .err   (err),
    .st    (state_q)
);

// File: tb/test_pulse_seq.sv
// Bench for pulse_seq: directed corner cases plus seeded random programs,
// checked cycle by cycle against a program interpreter written from the requirements.
module test_pulse_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        trig = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [11:0] wr_pattern = '0;
    logic [2:0]  wr_op = '0;
    logic [19:0] wr_operand = '0;
    logic [31:0] wr_dur = '0;
    logic [11:0] dout;
    logic        err;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    int b_pat [4096];
    int b_op  [4096];
    int b_opd [4096];
    int b_dur [4096];
    logic [11:0] e_pat [0:1999];
    bit          e_err [0:1999];

    pulse_seq i_pulse_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .trig(trig),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_pattern(wr_pattern), .wr_op(wr_op),
        .wr_operand(wr_operand), .wr_dur(wr_dur), .dout(dout), .err(err)
    );

    always #5 clk = ~clk;

    // watchdog: a hung run is one failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic raw_wr(int a, int pat, int op, int opd, int dur);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 12'(a); wr_pattern = 12'(pat);
        wr_op = 3'(op); wr_operand = 20'(opd); wr_dur = 32'(dur);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic put(int a, int pat, int op, int opd, int dur);
        raw_wr(a, pat, op, opd, dur);
        b_pat[a] = pat & 12'hFFF; b_op[a] = op; b_opd[a] = opd; b_dur[a] = dur;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // interpreter: expected dout/err after edge S+k for a start sampled at edge S
    task automatic build(int n, logic [11:0] prev);
        int t, pc, lsp, csp, steps, d, op;
        int la[8], lc[8], cr[8];
        bit done;
        for (int k = 0; k <= n; k++) begin e_pat[k] = prev; e_err[k] = 1'b0; end
        t = 2; pc = 0; lsp = 0; csp = 0; done = 1'b0; steps = 0;
        while (!done && t <= n && steps < 3000) begin
            steps++;
            op = b_op[pc];
            if ((op == 2 && lsp == 8) || (op == 3 && lsp == 0) ||
                (op == 4 && csp == 8) || (op == 5 && csp == 0)) begin
                for (int k = t; k <= n; k++) e_err[k] = 1'b1;
                done = 1'b1;
            end else begin
                d = (b_dur[pc] < 5) ? 5 : b_dur[pc];
                for (int k = t; k <= n; k++) e_pat[k] = 12'(b_pat[pc]);
                case (op)
                    1, 7: done = 1'b1;
                    2: begin la[lsp] = pc + 1; lc[lsp] = b_opd[pc]; lsp++; pc++; end
                    3: if (lc[lsp-1] != 0) begin lc[lsp-1]--; pc = la[lsp-1]; end
                       else begin lsp--; pc++; end
                    4: begin cr[csp] = pc + 1; csp++; pc = b_opd[pc] % 4096; end
                    5: begin csp--; pc = cr[csp]; end
                    6: pc = b_opd[pc] % 4096;
                    default: pc++;
                endcase
                pc = pc % 4096;
                t += d;
            end
        end
    endtask

    task automatic run(int n, string tag);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            chk($sformatf("%s dout k=%0d", tag, k), int'(dout), int'(e_pat[k]));
            chk($sformatf("%s err k=%0d", tag, k), int'(err), int'(e_err[k]));
        end
    endtask

    initial begin
        int nb, ln, tgt;
        void'($urandom(32'd2024));
        for (int i = 0; i < 4096; i++) begin b_pat[i] = 0; b_op[i] = 1; b_opd[i] = 0; b_dur[i] = 0; end

        // R1: reset state and idle hold
        do_reset();
        @(negedge clk);
        chk("R1 dout after reset", int'(dout), 0);
        chk("R1 err after reset", int'(err), 0);
        repeat (10) @(negedge clk);
        chk("R9 idle holds dout", int'(dout), 0);

        // R2 R3 R4: clamp and exact dwell, directed
        put(0, 12'h0A5, 0, 0, 0);
        put(1, 12'h15A, 0, 0, 4);
        put(2, 12'hFFF, 0, 0, 5);
        put(3, 12'h001, 0, 0, 1);
        put(4, 12'h800, 0, 0, 17);
        put(5, 12'h3C3, 1, 0, 9);
        build(70, 12'h000);
        run(70, "R2 R3 R4 dwell");

        // R3 R5 R6: seeded random programs with loop, call and branch
        for (int r = 0; r < 3; r++) begin
            do_reset();
            ln = $urandom_range(0, 3);
            nb = $urandom_range(1, 3);
            put(0, $urandom_range(0, 4095), 2, ln, $urandom_range(0, 9));
            for (int j = 1; j <= nb; j++) put(j, $urandom_range(0, 4095), 0, 0, $urandom_range(0, 9));
            put(nb + 1, $urandom_range(0, 4095), 4, 300, $urandom_range(0, 9));
            put(nb + 2, $urandom_range(0, 4095), 3, 0, $urandom_range(0, 9));
            put(nb + 3, $urandom_range(0, 4095), 6, nb + 5, $urandom_range(0, 9));
            put(nb + 4, 12'hBAD, 0, 0, 5);
            put(nb + 5, $urandom_range(0, 4095), 0, 0, $urandom_range(0, 9));
            put(nb + 6, $urandom_range(0, 4095), 1, 0, 0);
            put(300, $urandom_range(0, 4095), 2, 1, $urandom_range(0, 9));
            put(301, $urandom_range(0, 4095), 0, 0, $urandom_range(0, 9));
            put(302, $urandom_range(0, 4095), 3, 0, $urandom_range(0, 9));
            put(303, $urandom_range(0, 4095), 5, 0, $urandom_range(0, 9));
            build(700, 12'h000);
            run(700, "R3 R5 R6 random");
        end

        // R5: eight nested loops
        do_reset();
        for (int i = 0; i < 8; i++) put(i, 12'h010 + i, 2, (i >= 6) ? 1 : 0, 5);
        put(8, 12'h0F0, 0, 0, 6);
        for (int i = 9; i < 17; i++) put(i, 12'h100 + i, 3, 0, 5);
        put(17, 12'h777, 1, 0, 0);
        build(300, 12'h000);
        run(300, "R5 nest8");

        // R1: reset in mid-run clears stacks; the full nest must rerun cleanly
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 dout on mid-run reset", int'(dout), 0);
        chk("R1 err on mid-run reset", int'(err), 0);
        rst_n = 1'b1;
        build(300, 12'h000);
        run(300, "R1 rerun after reset");

        // R8: ninth loop push overflows; start then ignored
        do_reset();
        for (int i = 0; i < 9; i++) put(i, 12'h020 + i, 2, 0, 5);
        put(9, 12'h999, 1, 0, 0);
        build(80, 12'h000);
        run(80, "R8 loop overflow");
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (10) @(negedge clk);
        chk("R8 dout frozen after start", int'(dout), int'(e_pat[80]));
        chk("R8 err sticky after start", int'(err), 1);

        // R6: calls nested eight deep, then one more overflows
        do_reset();
        put(0, 12'h0C0, 4, 200, 5);
        put(1, 12'h0C1, 1, 0, 0);
        for (int i = 0; i < 7; i++) begin
            put(200 + 2 * i, 12'h200 + i, 4, 202 + 2 * i, 5);
            put(201 + 2 * i, 12'h300 + i, 5, 0, 5);
        end
        put(214, 12'h2FF, 0, 0, 7);
        put(215, 12'h3FF, 5, 0, 5);
        build(200, 12'h000);
        run(200, "R6 call depth 8");
        put(214, 12'h2EE, 4, 216, 5);
        put(216, 12'h111, 1, 0, 0);
        build(200, 12'h0C1);
        run(200, "R8 call overflow");

        // R8: return and end loop on empty stacks
        do_reset();
        put(0, 12'h05A, 0, 0, 6);
        put(1, 12'h0A5, 5, 0, 5);
        build(30, 12'h000);
        run(30, "R8 return underflow");
        do_reset();
        put(1, 12'h0A6, 3, 0, 5);
        build(30, 12'h000);
        run(30, "R8 end-loop underflow");

        // R9: stop holds, start reruns from address 0
        do_reset();
        put(0, 12'h123, 0, 0, 7);
        put(1, 12'h456, 1, 0, 3);
        build(30, 12'h000);
        run(30, "R9 first run");
        repeat (20) @(negedge clk);
        chk("R9 stop pattern held", int'(dout), 12'h456);
        build(30, 12'h456);
        run(30, "R9 restart");

        // R10: write during a run is dropped; write while idle is taken
        do_reset();
        put(0, 12'h0AA, 0, 0, 40);
        put(1, 12'h055, 0, 0, 5);
        put(2, 12'h0FF, 1, 0, 0);
        build(60, 12'h000);
        fork
            run(60, "R10 write while running");
            begin
                repeat (30) @(negedge clk);
                raw_wr(1, 12'hEEE, 0, 0, 5);
            end
        join
        put(1, 12'h0E1, 0, 0, 5);
        build(60, 12'h0FF);
        run(60, "R10 write while idle");

        // R7: wait ignores a held trigger, then responds 8 edges after a fresh edge
        do_reset();
        put(0, 12'h111, 0, 0, 6);
        put(1, 12'h222, 7, 0, 50);
        put(2, 12'h333, 0, 0, 5);
        put(3, 12'h444, 1, 0, 0);
        @(negedge clk); trig = 1'b1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (40) @(negedge clk);
        chk("R7 held trigger ignored", int'(dout), 12'h222);
        trig = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 waiting after trigger low", int'(dout), 12'h222);
        trig = 1'b1;
        @(negedge clk);
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            chk($sformatf("R7 before latency k=%0d", k), int'(dout), 12'h222);
        end
        @(negedge clk);
        chk("R7 pattern at trigger+8", int'(dout), 12'h333);
        repeat (5) @(negedge clk);
        chk("R7 stop after wait", int'(dout), 12'h444);
        trig = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule